// File: doc/BRIEF.md
# Six-Channel Vectored Interrupt Controller with Aggregated Sub-Sources

This block sits beside a small 8-bit microcontroller core and turns raw interrupt events into one registered request and a 16-bit vector address. It serves six channels. Channel k has vector 8·k + 3, so the vectors run 0003h, 000Bh, 0013h, 001Bh, 0023h and 002Bh. Each channel has an enable bit and a priority-level bit, and one global enable gates all channels. The winner is chosen in two levels. Any pending high-level channel beats every low-level channel. Within one level, the lower channel index wins.

Channel 2 (vector 0013h) has no line of its own. It collects seven sub-sources into a sticky status register that software reads to find out what fired, and clears by writing ones. Sub-source 0 is a pin that counts only on a falling edge. Sub-sources 1 to 6 are level or pulse event lines. Each sub-source has a mask bit. A masked sub-source still records its status, but it does not drive the channel 2 request.

The CPU side uses a simple handshake. Requests are evaluated only on a machine-cycle strobe. A granted request holds its vector until the CPU acknowledges it. A return-from-interrupt pulse then closes the innermost active service level.

Top module: `irq_vec_unit`

## Requirements
- R1: When a request is granted, `irq_req` rises and `irq_vec` equals 8·k + 3 for the winning channel k (0..5). The five `direct_req` bits feed channels 0, 1, 3, 4 and 5 in that order, and the aggregated sub-source request feeds channel 2.
- R2: Among pending channels of the same priority level, the lowest channel index is granted.
- R3: Priority register bit k set to 1 makes channel k high level. Any pending high-level channel is granted before any low-level channel.
- R4: A channel can be granted only if its enable bit (enable register bit k) is 1 and the global enable (enable register bit 7) is 1.
- R5: Status bit i+1 becomes 1 on any clock edge at which `sub_evt[i]` is high. Once set, it stays at 1 until it is cleared.
- R6: Status bit 0 is set only when `fall_pin` goes from 1 to 0. A rising edge does not set it, and neither does a pin held low.
- R7: Mask register bit i set to 1 stops status bit i from requesting channel 2, but the status bit is still recorded. Channel 2 requests while any status bit whose mask bit is 0 is set.
- R8: A write to the clear register (select 3) clears each status bit whose data bit is 1 and leaves the others unchanged. An event in the same cycle wins over the clear.
- R9: A new request is granted only in a cycle where `mc_tick` is 1.
- R10: `irq_req` and `irq_vec` stay constant until `irq_ack` is sampled high. The cycle after that, `irq_req` is 0.
- R11: Once a grant is acknowledged, its level becomes active. An active low level blocks further low-level grants but still allows high-level ones. An active high level blocks all grants. Each `reti` pulse closes the high level if it is active, and otherwise closes the low level.
- R12: After reset, `irq_req` is 0, `irq_vec` is 0, the status is 0, and all enable, priority and mask bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle strobe that allows a new grant |
| direct_req | input | 5 | Level requests for channels 0, 1, 3, 4, 5 |
| fall_pin | input | 1 | Sub-source 0 pin, falling-edge triggered |
| sub_evt | input | 6 | Sub-sources 1..6 event lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 enable, 1 priority, 2 mask, 3 status clear |
| cfg_wdata | input | 8 | Configuration write data |
| sub_status | output | 7 | Sticky sub-source status |
| irq_ack | input | 1 | CPU acknowledge of the current request |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 16 | Registered vector address |

## Verification
The bench uses the default configuration of six channels and seven sub-sources. This is small enough to sweep all 64 pending patterns against all 64 priority settings. For each of the 4096 pairs, the expected vector comes from a plain lowest-set-bit rule. Each sub-source then goes through the mask, edge and write-one-to-clear cases in turn. Short directed sequences cover nesting, strobe gating and the hold-until-acknowledge behaviour.

// File: rtl/irq_vec_pkg.sv
// Shared constants and types for the vectored interrupt controller.
package irq_vec_pkg;
    localparam int NUM_CH  = 6;   // interrupt channels
    localparam int NUM_SUB = 7;   // sub-sources folded into the aggregate channel
    localparam int AGG_CH  = 2;   // channel index fed by the aggregate
    localparam int VEC_W   = 16;  // vector address width
    localparam int CFG_W   = 8;   // configuration data width

    typedef enum logic [1:0] {
        CFG_ENABLE = 2'd0,
        CFG_LEVEL  = 2'd1,
        CFG_MASK   = 2'd2,
        CFG_CLEAR  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
// Configuration registers: per-channel enables, global enable, priority
// levels and sub-source masks, plus a write-one-to-clear strobe.
// Assumes one write per cycle, selected by sel.
module irq_cfg_regs
    import irq_vec_pkg::*;
#(
    parameter int N_CH  = NUM_CH,
    parameter int N_SUB = NUM_SUB,
    parameter int DW    = CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [DW-1:0]    wdata,
    output logic [N_CH-1:0]  chan_en,
    output logic             glob_en,
    output logic [N_CH-1:0]  chan_hi,
    output logic [N_SUB-1:0] sub_mask,
    output logic [N_SUB-1:0] clr_strobe
);
    cfg_sel_e sel_e;
    assign sel_e = cfg_sel_e'(sel);

    // Register writes, selected by sel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_en  <= '0;
            glob_en  <= 1'b0;
            chan_hi  <= '0;
            sub_mask <= '0;
        end else if (we) begin
            case (sel_e)
                CFG_ENABLE: begin
                    chan_en <= wdata[N_CH-1:0];
                    glob_en <= wdata[DW-1];
                end
                CFG_LEVEL:  chan_hi  <= wdata[N_CH-1:0];
                CFG_MASK:   sub_mask <= wdata[N_SUB-1:0];
                default:    ;
            endcase
        end
    end

    // Clear strobe for the sticky status, active only in a clear write.
    assign clr_strobe = (we && sel_e == CFG_CLEAR) ? wdata[N_SUB-1:0] : '0;
endmodule

// File: rtl/irq_sub_agg.sv
// Sub-source aggregator: edge-detects sub-source 0, latches every
// sub-source into sticky status, and ORs the unmasked bits into one request.
// Assumes event lines are synchronous to clk. Set wins over clear.
module irq_sub_agg #(
    parameter int N_SUB = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_pin,
    input  logic [N_SUB-2:0] evt,
    input  logic [N_SUB-1:0] mask,
    input  logic [N_SUB-1:0] clr,
    output logic [N_SUB-1:0] status,
    output logic             agg_req
);
    logic             pin_q;
    logic [N_SUB-1:0] hit;

    // Previous pin value. Reset low so a pin held low never counts as an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= fall_pin;
    end

    assign hit = {evt, pin_q & ~fall_pin};

    // Sticky status: clear selected bits, then OR in new hits.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | hit;
    end

    assign agg_req = |(status & ~mask);
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: returns the lowest set index of pend.
// Purely combinational.
module irq_prio_pick #(
    parameter int N     = 6,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set index is left in idx.
    always_comb begin
        valid = |pend;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_vec_unit.sv
// Top of the vectored interrupt controller. Masks channel requests with the
// enables, picks a high-level and a low-level winner, grants on mc_tick, and
// holds the registered vector until irq_ack. A two-bit in-service record
// handles one level of nesting. Assumes ack and reti never arrive together.
module irq_vec_unit
    import irq_vec_pkg::*;
#(
    parameter int N_CH  = NUM_CH,
    parameter int N_SUB = NUM_SUB,
    parameter int AGG   = AGG_CH,
    parameter int VW    = VEC_W,
    parameter int DW    = CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_tick,
    input  logic [N_CH-2:0]  direct_req,
    input  logic             fall_pin,
    input  logic [N_SUB-2:0] sub_evt,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [N_SUB-1:0] sub_status,
    input  logic             irq_ack,
    input  logic             reti,
    output logic             irq_req,
    output logic [VW-1:0]    irq_vec
);
    localparam int IDX_W = $clog2(N_CH);

    logic [N_CH-1:0]  chan_en, chan_hi, pend_raw, pend, hi_pend, lo_pend;
    logic             glob_en, agg_req;
    logic [N_SUB-1:0] sub_mask, clr_strobe;
    logic             hi_v, lo_v, take_hi, take_lo, lvl_q;
    logic             act_hi, act_lo;
    logic [IDX_W-1:0] hi_idx, lo_idx, win_idx;

    irq_cfg_regs #(.N_CH(N_CH), .N_SUB(N_SUB), .DW(DW)) i_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .chan_en(chan_en), .glob_en(glob_en),
        .chan_hi(chan_hi), .sub_mask(sub_mask), .clr_strobe(clr_strobe)
    );

    irq_sub_agg #(.N_SUB(N_SUB)) i_agg (
        .clk(clk), .rst_n(rst_n), .fall_pin(fall_pin), .evt(sub_evt),
        .mask(sub_mask), .clr(clr_strobe), .status(sub_status),
        .agg_req(agg_req)
    );

    // Channel map: the aggregate takes slot AGG, direct lines fill the rest.
    for (genvar c = 0; c < N_CH; c++) begin : g_map
        if (c == AGG) begin : g_agg
            assign pend_raw[c] = agg_req;
        end else if (c < AGG) begin : g_lo
            assign pend_raw[c] = direct_req[c];
        end else begin : g_hi
            assign pend_raw[c] = direct_req[c-1];
        end
    end

    assign pend    = pend_raw & chan_en & {N_CH{glob_en}};
    assign hi_pend = pend & chan_hi;
    assign lo_pend = pend & ~chan_hi;

    irq_prio_pick #(.N(N_CH), .IDX_W(IDX_W)) i_pick_hi (
        .pend(hi_pend), .valid(hi_v), .idx(hi_idx)
    );
    irq_prio_pick #(.N(N_CH), .IDX_W(IDX_W)) i_pick_lo (
        .pend(lo_pend), .valid(lo_v), .idx(lo_idx)
    );

    // Grant rules: an active high level blocks everything, an active low level blocks low.
    assign take_hi = hi_v && !act_hi;
    assign take_lo = !hi_v && lo_v && !act_hi && !act_lo;
    assign win_idx = take_hi ? hi_idx : lo_idx;

    // Request and vector registers: load on a tick, hold until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_vec <= '0;
            lvl_q   <= 1'b0;
        end else if (!irq_req) begin
            if (mc_tick && (take_hi || take_lo)) begin
                irq_req <= 1'b1;
                irq_vec <= VW'({win_idx, 3'b011});
                lvl_q   <= take_hi;
            end
        end else if (irq_ack) begin
            irq_req <= 1'b0;
        end
    end

    // In-service record: reti closes the innermost level, ack opens the granted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_hi <= 1'b0;
            act_lo <= 1'b0;
        end else if (reti) begin
            if (act_hi) act_hi <= 1'b0;
            else        act_lo <= 1'b0;
        end else if (irq_req && irq_ack) begin
            if (lvl_q) act_hi <= 1'b1;
            else       act_lo <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_vec_unit_chk.sv
// Temporal checks on the controller, attached to every instance through bind.
module irq_vec_unit_chk #(
    parameter int N_SUB = 7,
    parameter int VW    = 16,
    parameter int DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mc_tick,
    input logic             cfg_we,
    input logic [1:0]       cfg_sel,
    input logic [DW-1:0]    cfg_wdata,
    input logic [N_SUB-1:0] sub_status,
    input logic             irq_ack,
    input logic             irq_req,
    input logic [VW-1:0]    irq_vec,
    input logic             glob_en,
    input logic             act_hi
);
    p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

    p_ack_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack |=> !irq_req);

    p_vec_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'b011) && (irq_vec <= VW'(16'h002B)));

    p_tick_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req && !mc_tick |=> !irq_req);

    p_global_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req && !glob_en |=> !irq_req);

    p_no_preempt_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        act_hi && !irq_req |=> !irq_req);

    for (genvar i = 0; i < N_SUB; i++) begin : g_sticky
        p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            sub_status[i] && !(cfg_we && cfg_sel == 2'd3 && cfg_wdata[i])
            |=> sub_status[i]);
    end
endmodule

bind irq_vec_unit irq_vec_unit_chk #(.N_SUB(N_SUB), .VW(VW), .DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .sub_status(sub_status),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
    .glob_en(glob_en), .act_hi(act_hi)
);

// File: tb/test_irq_vec_unit.sv
// Self-checking bench: full pending-by-priority sweep plus directed sequences.
module test_irq_vec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_tick = 1'b0;
    logic [4:0]  direct_req = '0;
    logic        fall_pin = 1'b1;
    logic [5:0]  sub_evt = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [6:0]  sub_status;
    logic        irq_ack = 1'b0;
    logic        reti = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_vec_unit i_irq_vec_unit (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .direct_req(direct_req),
        .fall_pin(fall_pin), .sub_evt(sub_evt), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .sub_status(sub_status),
        .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic tick();
        mc_tick = 1'b1;
        step();
        mc_tick = 1'b0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic reti_pulse();
        reti = 1'b1; step(); reti = 1'b0;
    endtask

    // Channel index to direct_req bit: channels 0,1,3,4,5 -> bits 0..4.
    function automatic logic [4:0] to_direct(input logic [5:0] p);
        return {p[5], p[4], p[3], p[1], p[0]};
    endfunction

    function automatic logic [15:0] exp_vec(input logic [5:0] hi, input logic [5:0] p);
        logic [5:0] sel;
        sel = ((hi & p) != 0) ? (hi & p) : p;
        for (int k = 0; k < 6; k++) if (sel[k]) return 16'(k * 8 + 3);
        return 16'h0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R12: reset state
        chk("R12 req", irq_req, 0);
        chk("R12 vec", irq_vec, 0);
        chk("R12 status", sub_status, 0);
        direct_req = 5'b00001;
        tick();
        chk("R12 enables clear after reset", irq_req, 0);
        direct_req = '0;

        cfg_write(2'd0, 8'hBF);
        // R1 R2 R3: every pending pattern against every priority setting
        for (int hi = 0; hi < 64; hi++) begin
            cfg_write(2'd1, 8'(hi));
            for (int p = 0; p < 64; p++) begin
                direct_req = to_direct(6'(p));
                sub_evt[0] = p[2];
                step(); step();
                sub_evt[0] = 1'b0;
                tick();
                chk($sformatf("R1 R2 R3 req hi=%0h p=%0h", hi, p), irq_req, (p != 0));
                if (p != 0) begin
                    chk($sformatf("R1 R2 R3 vec hi=%0h p=%0h", hi, p), irq_vec, exp_vec(6'(hi), 6'(p)));
                    ack_pulse();
                    reti_pulse();
                end
                direct_req = '0;
                cfg_write(2'd3, 8'h7F);
            end
        end
        cfg_write(2'd1, 8'h00);

        // R5 R6 R7: each sub-source masked then unmasked
        for (int i = 0; i < 7; i++) begin
            cfg_write(2'd2, 8'(1 << i));
            if (i == 0) begin
                fall_pin = 1'b0; step(); fall_pin = 1'b1;
            end else begin
                sub_evt[i-1] = 1'b1; step(); sub_evt[i-1] = 1'b0;
            end
            chk($sformatf("R5 R6 status sub%0d", i), sub_status, 32'(1 << i));
            tick();
            chk($sformatf("R7 masked sub%0d no req", i), irq_req, 0);
            cfg_write(2'd2, 8'h00);
            tick();
            chk($sformatf("R7 unmasked sub%0d req", i), irq_req, 1);
            chk($sformatf("R7 unmasked sub%0d vec", i), irq_vec, 16'h13);
            ack_pulse();
            reti_pulse();
            cfg_write(2'd3, 8'(1 << i));
            chk($sformatf("R8 cleared sub%0d", i), sub_status, 0);
        end

        // R6: held low and rising edge do not set bit 0
        fall_pin = 1'b0; step();
        cfg_write(2'd3, 8'h01);
        step(); step();
        chk("R6 held low no retrigger", sub_status, 0);
        fall_pin = 1'b1; step(); step();
        chk("R6 rising edge ignored", sub_status, 0);

        // R8: selective clear and set-over-clear
        sub_evt[2:0] = 3'b111; step(); sub_evt[2:0] = '0;
        chk("R5 three bits set", sub_status, 7'h0E);
        cfg_write(2'd3, 8'h04);
        chk("R8 clear bit2 only", sub_status, 7'h0A);
        sub_evt[0] = 1'b1;
        cfg_write(2'd3, 8'h02);
        sub_evt[0] = 1'b0;
        chk("R8 set wins over clear", sub_status, 7'h0A);
        cfg_write(2'd3, 8'h7F);

        // R9: no grant without the strobe
        direct_req = 5'b00001;
        step(); step(); step();
        chk("R9 no tick no grant", irq_req, 0);

        // R4: global and per-channel enables
        cfg_write(2'd0, 8'h3F);
        tick();
        chk("R4 global off", irq_req, 0);
        cfg_write(2'd0, 8'hBE);
        tick();
        chk("R4 channel off", irq_req, 0);
        cfg_write(2'd0, 8'hBF);
        tick();
        chk("R4 enabled req", irq_req, 1);
        chk("R4 enabled vec", irq_vec, 16'h03);
        ack_pulse(); reti_pulse();
        direct_req = '0;

        // R10: vector held until acknowledge
        direct_req = 5'b00100;
        tick();
        chk("R10 first vec", irq_vec, 16'h1B);
        direct_req = 5'b00101;
        tick(); tick();
        chk("R10 held req", irq_req, 1);
        chk("R10 held vec", irq_vec, 16'h1B);
        ack_pulse();
        chk("R10 drop after ack", irq_req, 0);
        reti_pulse();
        direct_req = '0;

        // R11: nesting rules
        cfg_write(2'd1, 8'h20);
        direct_req = 5'b00001;
        tick();
        chk("R11 low grant", irq_vec, 16'h03);
        ack_pulse();
        tick();
        chk("R11 low blocks low", irq_req, 0);
        direct_req = 5'b10001;
        tick();
        chk("R11 high preempts low req", irq_req, 1);
        chk("R11 high preempts low vec", irq_vec, 16'h2B);
        ack_pulse();
        cfg_write(2'd1, 8'h21);
        tick();
        chk("R11 high not preempted", irq_req, 0);
        direct_req = 5'b00001;
        reti_pulse();
        tick();
        chk("R11 after pop high req", irq_req, 1);
        chk("R11 after pop high vec", irq_vec, 16'h03);
        ack_pulse();
        reti_pulse();
        reti_pulse();
        direct_req = 5'b00100;
        cfg_write(2'd1, 8'h00);
        tick();
        chk("R11 both popped req", irq_req, 1);
        chk("R11 both popped vec", irq_vec, 16'h1B);
        ack_pulse(); reti_pulse();
        direct_req = '0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule